// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the head of a receive path and decides whether an incoming frame is kept. It watches the first six bytes of the frame, the destination address, as they arrive one per cycle. A start strobe marks the first byte. It registers the address and keeps a running CRC-32 over it. In the cycle after the sixth byte it raises a one-cycle valid strobe together with an accept flag.

The accept decision is set by five mode bits, a 64-bit multicast hash table and a small bank of exact-match address entries, each with its own enable. All are loaded through simple write ports. The hash index is taken from the complemented, bit-reversed CRC of the address. An all-ones destination is always kept. The host can enable several paths at once: pass everything, pass all group addresses, pass group addresses whose hash bit is set, pass listed individual addresses, and a combined mode in which either a hash hit or an exact match is enough.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are low, all mode bits are clear, the hash table is all zeros and every exact-match entry is disabled. In that state an individual (non-group) address is rejected.
- R2: dec_valid is high for exactly one cycle. That cycle is the one after the clock edge that takes the sixth address byte. dec_accept is low whenever dec_valid is low. Bytes with rx_valid high and rx_start low are ignored in two cases: after six bytes have been taken, and when no start has been seen since reset.
- R3: A byte with rx_valid and rx_start both high always begins a new address, even in the middle of one. The partial address is discarded and the CRC is preset to all ones again.
- R4: The hash index is built from the CRC-32 (reflected polynomial 0xEDB88320, preset 0xFFFFFFFF). The CRC runs over the six bytes in arrival order, least significant bit of each byte first. With c the final CRC register, index bit 5-k equals the inverse of c[k] for k = 0..5. Index bit 5 selects the high table word (written with hash_hi_sel=1) or the low word (hash_hi_sel=0). Index bits 4:0 select the bit within that word.
- R5: With mode bit 0 (promiscuous) set, every address is accepted.
- R6: The broadcast address, all 48 bits one, is accepted in every mode.
- R7: With mode bit 1 (all group) set, every address whose group bit is set is accepted without a table lookup. The group bit is bit 0 of the first received byte.
- R8: With mode bit 2 (group hash) set, a group address is accepted when its indexed table bit is one. With only this bit set, it is rejected otherwise.
- R9: With mode bit 4 (exact individual) set, an individual address is accepted when it equals an enabled entry. An entry is written as perf_wdata[48] = enable and perf_wdata[47:0] = address, with the first received byte in bits 7:0. A disabled entry never matches.
- R10: With mode bit 3 (hash or exact) set, an address of either kind is accepted when its table bit is one or it equals an enabled entry.
- R11: With no mode bit set, every address other than broadcast is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_start | input | 1 | Marks the first destination byte of a frame |
| rx_byte | input | 8 | Received byte |
| mode_we | input | 1 | Write strobe for the mode bits |
| mode_wdata | input | 5 | Mode bits: 0 promiscuous, 1 all group, 2 group hash, 3 hash or exact, 4 exact individual |
| hash_we | input | 1 | Write strobe for one hash table word |
| hash_hi_sel | input | 1 | 1 selects the high table word, 0 the low word |
| hash_wdata | input | 32 | Hash table word |
| perf_we | input | 1 | Write strobe for an exact-match entry |
| perf_idx | input | PIDX_W (2) | Entry number |
| perf_wdata | input | 49 | Bit 48 enable, bits 47:0 address |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted; meaningful when dec_valid is high |

## Verification
The bench first runs addresses under each mode bit on its own: random individual and group addresses, the broadcast address, and addresses copied from enabled and disabled entries. These separate the acceptance paths from one another. A directed case sets only the one table bit named by the independently computed CRC, then every bit except that one. This exposes a wrong bit order, a missing complement or a swapped word. Restarts in the middle of an address, bytes that arrive before any start, payload bytes after the sixth byte and idle gaps of different lengths check the byte counting. A long random phase then mixes the modes, table contents and entries.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HASH_IDX_W = 6;
  localparam int HASH_W     = 1 << HASH_IDX_W;
  localparam int MODE_W     = 5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

  // bit 0 promiscuous ... bit 4 exact individual
  typedef struct packed {
    logic uc_exact;
    logic hash_or_exact;
    logic grp_hash;
    logic all_grp;
    logic promisc;
  } mode_t;

  // one byte into a reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                             input logic [7:0]  data);
    logic [31:0] r;
    r = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ data[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else                r = r >> 1;
    end
    return r;
  endfunction

  // index = top bits of bitreverse(~crc): index[5-k] = ~crc[k]
  function automatic logic [HASH_IDX_W-1:0] hash_index(input logic [HASH_IDX_W-1:0] crc_lo);
    logic [HASH_IDX_W-1:0] idx;
    for (int k = 0; k < HASH_IDX_W; k++) idx[HASH_IDX_W-1-k] = ~crc_lo[k];
    return idx;
  endfunction

endpackage

// File: rtl/afilt_capture.sv
module afilt_capture
  import afilt_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_start,
  input  logic [7:0]            in_byte,
  output logic [8*NBYTES-1:0]   addr_q,
  output logic [31:0]           crc_q,
  output logic                  done_q,
  output logic                  last_take
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] FULL_C = CW'(NBYTES);
  localparam logic [CW-1:0] LAST_C = CW'(NBYTES - 1);

  logic [CW-1:0] cnt_q;
  logic          first_take;
  logic          more_take;

  assign first_take = in_valid & in_start;
  assign more_take  = in_valid & ~in_start & (cnt_q != '0) & (cnt_q < FULL_C);
  assign last_take  = (first_take && (NBYTES == 1)) || (more_take && (cnt_q == LAST_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= CRC_PRESET;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_take;
      if (first_take) begin
        cnt_q        <= CW'(1);
        crc_q        <= crc32_byte(CRC_PRESET, in_byte);
        addr_q[7:0]  <= in_byte;
      end else if (more_take) begin
        cnt_q                         <= cnt_q + CW'(1);
        crc_q                         <= crc32_byte(crc_q, in_byte);
        addr_q[8*int'(cnt_q) +: 8]    <= in_byte;
      end
    end
  end

endmodule

// File: rtl/afilt_cfg.sv
module afilt_cfg
  import afilt_pkg::*;
#(
  parameter int NUM_PERF = 4,
  parameter int PIDX_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             mode_we,
  input  logic [MODE_W-1:0]                mode_wdata,
  input  logic                             hash_we,
  input  logic                             hash_hi_sel,
  input  logic [HASH_W/2-1:0]              hash_wdata,
  input  logic                             perf_we,
  input  logic [PIDX_W-1:0]                perf_idx,
  input  logic [ADDR_W:0]                  perf_wdata,
  output mode_t                            mode_q,
  output logic [HASH_W-1:0]                hash_q,
  output logic [NUM_PERF-1:0][ADDR_W-1:0]  ent_addr_q,
  output logic [NUM_PERF-1:0]              ent_en_q
);
  localparam int HALF = HASH_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_t'(mode_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_q <= '0;
    end else if (hash_we) begin
      if (hash_hi_sel) hash_q[HASH_W-1:HALF] <= hash_wdata;
      else             hash_q[HALF-1:0]      <= hash_wdata;
    end
  end

  for (genvar g = 0; g < NUM_PERF; g++) begin : g_ent
    logic sel;
    assign sel = perf_we && (perf_idx == PIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr_q[g] <= '0;
        ent_en_q[g]   <= 1'b0;
      end else if (sel) begin
        ent_addr_q[g] <= perf_wdata[ADDR_W-1:0];
        ent_en_q[g]   <= perf_wdata[ADDR_W];
      end
    end
  end

endmodule

// File: rtl/afilt_perfect_bank.sv
module afilt_perfect_bank
  import afilt_pkg::*;
#(
  parameter int NUM_PERF = 4
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_PERF-1:0][ADDR_W-1:0]  ent_addr,
  input  logic [NUM_PERF-1:0]              ent_en,
  output logic                             hit
);
  logic [NUM_PERF-1:0] hit_vec;

  for (genvar g = 0; g < NUM_PERF; g++) begin : g_cmp
    assign hit_vec[g] = ent_en[g] && (ent_addr[g] == addr);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
  import afilt_pkg::*;
(
  input  mode_t                  mode,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [HASH_IDX_W-1:0]  crc_lo,
  input  logic [HASH_W-1:0]      hash_tbl,
  input  logic                   perf_hit,
  output logic                   accept,
  output logic                   is_bcast,
  output logic                   is_group,
  output logic                   hash_hit
);
  logic [HASH_IDX_W-1:0] idx;
  logic                  either_hit;
  logic                  grp_ok;
  logic                  ind_ok;

  assign idx        = hash_index(crc_lo);
  assign hash_hit   = hash_tbl[idx];
  assign is_bcast   = &addr;
  assign is_group   = addr[0];
  assign either_hit = hash_hit | perf_hit;

  assign grp_ok = mode.all_grp
                | (mode.grp_hash & hash_hit)
                | (mode.hash_or_exact & either_hit);
  assign ind_ok = (mode.uc_exact & perf_hit)
                | (mode.hash_or_exact & either_hit);

  assign accept = is_bcast | mode.promisc | (is_group ? grp_ok : ind_ok);

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import afilt_pkg::*;
#(
  parameter int NUM_PERF = 4,
  parameter int PIDX_W   = (NUM_PERF > 1) ? $clog2(NUM_PERF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_start,
  input  logic [7:0]        rx_byte,
  input  logic              mode_we,
  input  logic [4:0]        mode_wdata,
  input  logic              hash_we,
  input  logic              hash_hi_sel,
  input  logic [31:0]       hash_wdata,
  input  logic              perf_we,
  input  logic [PIDX_W-1:0] perf_idx,
  input  logic [48:0]       perf_wdata,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic [ADDR_W-1:0]                addr_q;
  logic [31:0]                      crc_q;
  logic                             done_q;
  logic                             last_take;
  mode_t                            mode_q;
  logic [MODE_W-1:0]                mode_bits;
  logic [HASH_W-1:0]                hash_q;
  logic [NUM_PERF-1:0][ADDR_W-1:0]  ent_addr_q;
  logic [NUM_PERF-1:0]              ent_en_q;
  logic                             perf_hit;
  logic                             hash_hit;
  logic                             is_bcast;
  logic                             is_group;
  logic                             accept;

  afilt_capture #(.NBYTES(ADDR_BYTES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_start  (rx_start),
    .in_byte   (rx_byte),
    .addr_q    (addr_q),
    .crc_q     (crc_q),
    .done_q    (done_q),
    .last_take (last_take)
  );

  afilt_cfg #(.NUM_PERF(NUM_PERF), .PIDX_W(PIDX_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_we     (mode_we),
    .mode_wdata  (mode_wdata),
    .hash_we     (hash_we),
    .hash_hi_sel (hash_hi_sel),
    .hash_wdata  (hash_wdata),
    .perf_we     (perf_we),
    .perf_idx    (perf_idx),
    .perf_wdata  (perf_wdata),
    .mode_q      (mode_q),
    .hash_q      (hash_q),
    .ent_addr_q  (ent_addr_q),
    .ent_en_q    (ent_en_q)
  );

  afilt_perfect_bank #(.NUM_PERF(NUM_PERF)) u_bank (
    .addr     (addr_q),
    .ent_addr (ent_addr_q),
    .ent_en   (ent_en_q),
    .hit      (perf_hit)
  );

  afilt_decide u_dec (
    .mode     (mode_q),
    .addr     (addr_q),
    .crc_lo   (crc_q[HASH_IDX_W-1:0]),
    .hash_tbl (hash_q),
    .perf_hit (perf_hit),
    .accept   (accept),
    .is_bcast (is_bcast),
    .is_group (is_group),
    .hash_hit (hash_hit)
  );

  assign mode_bits  = mode_q;
  assign dec_valid  = done_q;
  assign dec_accept = done_q & accept;

endmodule

// File: rtl/afilt_chk.sv
module afilt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic       last_take,
  input logic [4:0] mode,
  input logic       is_bcast,
  input logic       is_group,
  input logic       perf_hit,
  input logic       hash_hit
);

  // R2
  sixth_byte_decides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> dec_valid);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R5
  promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && mode[0]) |-> dec_accept);

  // R6
  bcast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && is_bcast) |-> dec_accept);

  // R7
  all_group_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && is_group && mode[1]) |-> dec_accept);

  // R8
  grp_hash_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && is_group && !is_bcast && mode == 5'b00100) |-> (dec_accept == hash_hit));

  // R9
  exact_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !is_group && mode == 5'b10000) |-> (dec_accept == perf_hit));

  // R10
  hash_or_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && mode[3] && (hash_hit || perf_hit)) |-> dec_accept);

  // R11
  no_mode_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && mode == 5'b00000 && !is_bcast) |-> !dec_accept);

endmodule

bind dst_addr_filter afilt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .last_take  (last_take),
  .mode       (mode_bits),
  .is_bcast   (is_bcast),
  .is_group   (is_group),
  .perf_hit   (perf_hit),
  .hash_hit   (hash_hit)
);

// File: tb/tb_dst_addr_filter.sv
`timescale 1ns/1ps
module tb_dst_addr_filter;

  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_start = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        mode_we = 1'b0, hash_we = 1'b0, hash_hi_sel = 1'b0, perf_we = 1'b0;
  logic [4:0]  mode_wdata = '0;
  logic [31:0] hash_wdata = '0;
  logic [1:0]  perf_idx = '0;
  logic [48:0] perf_wdata = '0;
  logic        dec_valid, dec_accept;

  int    vectors = 0;
  int    fails   = 0;
  string cur_req = "R1";
  bit    checking = 0;
  bit    last_vld, last_acc;

  // reference state
  logic [7:0]  m_a [6];
  int          m_cnt = 0;
  bit          m_valid = 0;
  logic [4:0]  m_mode = '0;
  logic [63:0] m_hash = '0;
  logic [47:0] m_ent [NE];
  bit          m_en  [NE];

  always #2 clk = ~clk;

  dst_addr_filter #(.NUM_PERF(NE)) dut (
    .clk, .rst_n, .rx_valid, .rx_start, .rx_byte,
    .mode_we, .mode_wdata, .hash_we, .hash_hi_sel, .hash_wdata,
    .perf_we, .perf_idx, .perf_wdata, .dec_valid, .dec_accept
  );

  // CRC in the non-reflected form: its complement's top bits are the index
  function automatic int ref_idx();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        bit fb = c[31] ^ m_a[k][i];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    c = ~c;
    return int'(c[31:26]);
  endfunction

  function automatic bit ref_accept();
    bit bc = 1, grp, hh, ph = 0;
    for (int k = 0; k < 6; k++) if (m_a[k] != 8'hFF) bc = 0;
    grp = m_a[0][0];
    hh  = m_hash[ref_idx()];
    for (int e = 0; e < NE; e++)
      if (m_en[e] && m_ent[e] == {m_a[5], m_a[4], m_a[3], m_a[2], m_a[1], m_a[0]}) ph = 1;
    if (bc || m_mode[0]) return 1;
    if (m_mode[3] && (hh || ph)) return 1;
    if (grp) return m_mode[1] || (m_mode[2] && hh);
    return m_mode[4] && ph;
  endfunction

  always @(posedge clk) begin
    m_valid = 0;
    if (!rst_n) begin
      m_cnt = 0; m_mode = '0; m_hash = '0;
      for (int e = 0; e < NE; e++) begin m_en[e] = 0; m_ent[e] = '0; end
    end else begin
      if (rx_valid && rx_start) begin
        m_a[0] = rx_byte; m_cnt = 1;
      end else if (rx_valid && m_cnt > 0 && m_cnt < 6) begin
        m_a[m_cnt] = rx_byte; m_cnt++;
        if (m_cnt == 6) m_valid = 1;
      end
      if (mode_we) m_mode = mode_wdata;
      if (hash_we) begin
        if (hash_hi_sel) m_hash[63:32] = hash_wdata; else m_hash[31:0] = hash_wdata;
      end
      if (perf_we) begin m_en[perf_idx] = perf_wdata[48]; m_ent[perf_idx] = perf_wdata[47:0]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking) begin
      vectors++;
      if (dec_valid !== m_valid) begin
        fails++;
        $display("FAIL %s dec_valid actual %b expected %b", cur_req, dec_valid, m_valid);
      end else if (dec_accept !== (m_valid ? ref_accept() : 1'b0)) begin
        fails++;
        $display("FAIL %s dec_accept actual %b expected %b", cur_req, dec_accept,
                 m_valid ? ref_accept() : 1'b0);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  task automatic check(string req, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic [4:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_hash(bit hi, logic [31:0] w);
    @(negedge clk); hash_we = 1; hash_hi_sel = hi; hash_wdata = w;
    @(negedge clk); hash_we = 0;
  endtask

  task automatic wr_ent(int idx, bit en, logic [47:0] a);
    @(negedge clk); perf_we = 1; perf_idx = 2'(idx); perf_wdata = {en, a};
    @(negedge clk); perf_we = 0;
  endtask

  task automatic send_bytes(logic [47:0] a, int n, bit with_start);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_start = with_start && (k == 0); rx_byte = a[8*k +: 8];
    end
  endtask

  // six bytes, then samples the decision cycle
  task automatic send_addr(logic [47:0] a);
    send_bytes(a, 6, 1);
    @(negedge clk);
    rx_valid = 0; rx_start = 0;
    last_vld = dec_valid; last_acc = dec_accept;
  endtask

  function automatic int idx_of(logic [47:0] a);
    for (int k = 0; k < 6; k++) m_a[k] = a[8*k +: 8];
    return ref_idx();
  endfunction

  logic [47:0] uc_a = 48'h5544_3322_1100;
  logic [47:0] mc_a = 48'h0605_0403_0201;
  logic [47:0] bc_a = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", dec_valid, 0);
    check("R1", dec_accept, 0);
    rst_n = 1; checking = 1;
    // R2: bytes before any start are ignored
    cur_req = "R2";
    send_bytes(uc_a, 6, 0);
    @(negedge clk); rx_valid = 0;
    check("R2", dec_valid, 0);
    cur_req = "R1";
    send_addr(uc_a);
    check("R1", last_vld, 1); check("R1", last_acc, 0);
    cur_req = "R11";
    send_addr(mc_a); check("R11", last_acc, 0);
    cur_req = "R6";
    send_addr(bc_a); check("R6", last_acc, 1);
    // R2: payload bytes after the address do not raise a decision
    cur_req = "R2";
    send_bytes(uc_a, 6, 1); send_bytes(mc_a, 4, 0);
    @(negedge clk); rx_valid = 0;
    repeat (2) @(negedge clk);

    cur_req = "R5";
    wr_mode(5'b00001);
    send_addr(uc_a); check("R5", last_acc, 1);
    send_addr(mc_a); check("R5", last_acc, 1);

    cur_req = "R7";
    wr_mode(5'b00010);
    send_addr(mc_a); check("R7", last_acc, 1);
    send_addr(uc_a); check("R7", last_acc, 0);

    // R4 / R8: only the computed index bit set, then all other bits
    cur_req = "R4";
    wr_mode(5'b00100);
    begin
      int ix = idx_of(mc_a);
      logic [63:0] t = 64'd1 << ix;
      wr_hash(1, t[63:32]); wr_hash(0, t[31:0]);
      send_addr(mc_a); check("R4", last_acc, 1);
      wr_hash(1, ~t[63:32]); wr_hash(0, ~t[31:0]);
      send_addr(mc_a); check("R8", last_acc, 0);
    end
    wr_hash(1, '0); wr_hash(0, '0);

    cur_req = "R9";
    wr_mode(5'b10000);
    wr_ent(1, 1, uc_a);
    wr_ent(2, 0, 48'h0000_0000_AA10);
    send_addr(uc_a); check("R9", last_acc, 1);
    send_addr(48'h0000_0000_AA10); check("R9", last_acc, 0);
    send_addr(48'h5544_3322_1102); check("R9", last_acc, 0);

    cur_req = "R10";
    wr_mode(5'b01000);
    send_addr(uc_a); check("R10", last_acc, 1);
    send_addr(mc_a); check("R10", last_acc, 0);
    begin
      int ix = idx_of(mc_a);
      logic [63:0] t = 64'd1 << ix;
      wr_hash(1, t[63:32]); wr_hash(0, t[31:0]);
      send_addr(mc_a); check("R10", last_acc, 1);
    end

    // R3: restart in the middle of an address
    cur_req = "R3";
    wr_hash(1, '0); wr_hash(0, '0);
    wr_mode(5'b10000);
    send_bytes(48'hDEAD_BEEF_CAFE, 3, 1);
    send_addr(uc_a); check("R3", last_vld, 1); check("R3", last_acc, 1);
    wr_mode(5'b00100);
    begin
      int ix = idx_of(mc_a);
      logic [63:0] t = 64'd1 << ix;
      wr_hash(1, t[63:32]); wr_hash(0, t[31:0]);
      send_bytes(48'h1234_5678_9ABC, 5, 1);
      send_addr(mc_a); check("R3", last_acc, 1);
    end

    // random mix; reference compared every cycle
    cur_req = "R10";
    for (int n = 0; n < 400; n++) begin
      logic [47:0] a;
      int r = $urandom_range(0, 9);
      if (n % 40 == 0) begin
        wr_mode(5'($urandom_range(0, 31)));
        wr_hash(1, $urandom); wr_hash(0, $urandom);
        wr_ent($urandom_range(0, NE-1), 1'($urandom_range(0, 1)), {$urandom, $urandom} );
      end
      a = {$urandom, $urandom};
      if (r == 0) a = bc_a;
      else if (r < 4) a = m_ent[$urandom_range(0, NE-1)];
      send_bytes(a, 6, 1);
      @(negedge clk); rx_valid = 0; rx_start = 0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule